// File: doc/BRIEF.md
# Global Performance-Monitor Control and Interrupt Router

This block is the central control point for a set of distributed event counters. Software programs a global control word that enables all counters at once and chooses how an overflow interrupt is delivered. Overflow pulses arrive from two groups of programmable counters: the cache-slice counters and the arbiter counters. A third source is the block's own free-running cycle counter. Each overflow sets a sticky status bit, and software clears these bits with write-one-to-clear.

When an accepted overflow first appears, the block raises one interrupt. It routes the interrupt to a chosen subset of cores. In wake mode, each chosen core gets a wake request first, and its interrupt pulse follows once the core reports that it is awake. Without wake mode, only chosen cores that are already awake get the pulse. A freeze option drops the global enable when the interrupt is raised, and counting stays stopped until software sets the enable again.

Software accesses the block through one write port with a 2-bit register select: 0 control, 1 status, 2 cycle-counter control, 3 cycle-counter value. Each register is also visible on its own readback output.

Top module: `pmu_global_ctl`

## Requirements
- R1: Control register fields are bit 29 global enable (driven on `glb_en_o`), bit 30 wake mode, bit 31 freeze, and bits 3:0 core select. All other bits read back as zero.
- R2: If freeze (bit 31) is set when an interrupt is raised, the global enable clears on that clock edge. Counting stays stopped until software writes bit 29 to one again.
- R3: Status bits are sticky. Bit 0 is set by a cycle-counter overflow, bit 1 by any arbiter overflow pulse, and bit 3 by any cache-slice overflow pulse. Bit 2 always reads zero.
- R4: Writing the status register clears each bit written as one and leaves bits written as zero unchanged. If a bit is set by hardware in the same cycle, the set wins over the clear.
- R5: The 48-bit cycle counter increments on each clock only when control bit 22 of its own control word and the global enable are both set. A write to register 3 loads it. It wraps from all ones to zero.
- R6: A cycle-counter wrap always sets status bit 0. It is an interrupt source only when bit 20 of the counter's control word is set.
- R7: An interrupt is raised once, on the rising edge of the OR of accepted overflow pulses. Each resulting `pmi_o` pulse lasts exactly one cycle.
- R8: With wake mode off, a selected core gets a `pmi_o` pulse in the cycle after the interrupt is raised only if its `core_awake_i` was high when the interrupt was raised. Unselected or sleeping cores get nothing, and `wake_req_o` stays low.
- R9: With wake mode on, `wake_req_o` of each selected core goes high in the cycle after the interrupt is raised and stays high until that core's `core_awake_i` is high at a clock edge. The core's `pmi_o` pulse follows in the cycle after that edge.
- R10: Reset clears the control word, the cycle-counter control word, the status bits and the cycle counter.
- R11: The cycle-counter control word holds only bit 22 (count enable) and bit 20 (overflow enable). All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Uncore clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 status, 2 counter control, 3 counter value |
| cfg_wdata | input | 64 | Register write data |
| slice_ovf_i | input | 8 | Overflow pulses from cache-slice counters |
| arb_ovf_i | input | 2 | Overflow pulses from arbiter counters |
| core_awake_i | input | 4 | Per-core awake indication |
| glb_en_o | output | 1 | Global enable to all counters |
| ctrl_o | output | 32 | Control register readback |
| status_o | output | 4 | Status register readback |
| fix_ctl_o | output | 32 | Cycle-counter control readback |
| fix_cnt_o | output | 48 | Cycle-counter value |
| wake_req_o | output | 4 | Per-core wake request |
| pmi_o | output | 4 | Per-core interrupt pulse |

## Verification
The bench drives the cycle counter across its wrap twice: once with the overflow enable cleared and once with it set. A design that forwarded every wrap would raise a stray interrupt, and one that gated the status bit would lose the record. An overflow input held high for several cycles must produce a single pulse, and a pulse-per-cycle design would show repeated interrupts. A hardware set landing on a software clear must leave the bit set, and routing with one core asleep must skip that core without wake mode and hold its wake request until it wakes with wake mode. The freeze case checks that the counter value stays frozen until the enable is rewritten, which catches a freeze that only blocks new interrupts.

// File: rtl/pmu_glb_pkg.sv
package pmu_glb_pkg;

    // register select codes on the write port
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_FIXCTL = 2'd2,
        SEL_FIXCNT = 2'd3
    } cfg_sel_e;

    // control register bit positions
    localparam int CTL_EN_BIT     = 29;
    localparam int CTL_WAKE_BIT   = 30;
    localparam int CTL_FREEZE_BIT = 31;

    // cycle-counter control bit positions
    localparam int FIX_RUN_BIT    = 22;
    localparam int FIX_OVFEN_BIT  = 20;

    // status bit positions
    localparam int ST_W           = 4;
    localparam int ST_FIX         = 0;
    localparam int ST_ARB         = 1;
    localparam int ST_RSVD        = 2;
    localparam int ST_SLICE       = 3;

    localparam int RDBK_W         = 32;

    // per-core delivery states
    typedef enum logic [1:0] {
        DLV_IDLE = 2'd0,
        DLV_WAIT = 2'd1,
        DLV_SEND = 2'd2
    } dlv_state_e;

endpackage

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cyc_t;

    cyc_t           c_d, c_q;
    logic [CNT_W:0] sum;

    always_comb begin
        c_d    = c_q;
        sum    = {1'b0, c_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        wrap_o = 1'b0;
        if (ld_i) begin
            c_d.cnt = ld_val_i;
        end else if (run_i) begin
            c_d.cnt = sum[CNT_W-1:0];
            wrap_o  = sum[CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o = c_q.cnt;
endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status
    import pmu_glb_pkg::*;
#(
    parameter int N_SLICE_OVF = 8,
    parameter int N_ARB_OVF   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fix_wrap_i,
    input  logic                   fix_ovf_en_i,
    input  logic [N_ARB_OVF-1:0]   arb_ovf_i,
    input  logic [N_SLICE_OVF-1:0] slice_ovf_i,
    input  logic                   clr_we_i,
    input  logic [ST_W-1:0]        clr_bits_i,
    output logic [ST_W-1:0]        status_o,
    output logic                   fire_o
);
    typedef struct packed {
        logic [ST_W-1:0] st;
        logic            src;
    } ovs_t;

    ovs_t            s_d, s_q;
    logic [ST_W-1:0] set_v;
    logic [ST_W-1:0] clr_v;
    logic            accepted;

    always_comb begin
        set_v           = '0;
        set_v[ST_FIX]   = fix_wrap_i;
        set_v[ST_ARB]   = |arb_ovf_i;
        set_v[ST_SLICE] = |slice_ovf_i;
        clr_v           = clr_we_i ? clr_bits_i : '0;
        accepted        = (fix_wrap_i & fix_ovf_en_i) | (|arb_ovf_i) | (|slice_ovf_i);

        s_d             = s_q;
        // hardware set takes priority over a same-cycle clear
        s_d.st          = (s_q.st & ~clr_v) | set_v;
        s_d.st[ST_RSVD] = 1'b0;
        s_d.src         = accepted;
        fire_o          = accepted & ~s_q.src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.st;
endmodule

// File: rtl/pmu_pmi_seq.sv
module pmu_pmi_seq
    import pmu_glb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic wake_mode_i,
    input  logic awake_i,
    output logic wake_req_o,
    output logic pmi_o
);
    typedef struct packed {
        dlv_state_e st;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        unique case (q_q.st)
            DLV_IDLE: begin
                if (start_i) begin
                    if (wake_mode_i)  q_d.st = DLV_WAIT;
                    else if (awake_i) q_d.st = DLV_SEND;
                end
            end
            DLV_WAIT: begin
                if (awake_i) q_d.st = DLV_SEND;
            end
            DLV_SEND: q_d.st = DLV_IDLE;
            default:  q_d.st = DLV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: DLV_IDLE};
        else        q_q <= q_d;
    end

    assign wake_req_o = (q_q.st == DLV_WAIT);
    assign pmi_o      = (q_q.st == DLV_SEND);
endmodule

// File: rtl/pmu_global_ctl.sv
module pmu_global_ctl
    import pmu_glb_pkg::*;
#(
    parameter int N_CORE      = 4,
    parameter int N_SLICE_OVF = 8,
    parameter int N_ARB_OVF   = 2,
    parameter int CNT_W       = 48,
    parameter int REG_W       = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [REG_W-1:0]       cfg_wdata,
    input  logic [N_SLICE_OVF-1:0] slice_ovf_i,
    input  logic [N_ARB_OVF-1:0]   arb_ovf_i,
    input  logic [N_CORE-1:0]      core_awake_i,
    output logic                   glb_en_o,
    output logic [RDBK_W-1:0]      ctrl_o,
    output logic [ST_W-1:0]        status_o,
    output logic [RDBK_W-1:0]      fix_ctl_o,
    output logic [CNT_W-1:0]       fix_cnt_o,
    output logic [N_CORE-1:0]      wake_req_o,
    output logic [N_CORE-1:0]      pmi_o
);
    typedef struct packed {
        logic              freeze;
        logic              wake;
        logic              en;
        logic [N_CORE-1:0] sel;
        logic              fix_run;
        logic              fix_ovf_en;
    } ctl_t;

    ctl_t r_d, r_q;
    logic irq_fire;
    logic fix_wrap;
    logic wr_ctrl, wr_stat, wr_fctl, wr_fcnt;
    logic unused_wdata;

    assign wr_ctrl      = cfg_we && (cfg_sel == SEL_CTRL);
    assign wr_stat      = cfg_we && (cfg_sel == SEL_STATUS);
    assign wr_fctl      = cfg_we && (cfg_sel == SEL_FIXCTL);
    assign wr_fcnt      = cfg_we && (cfg_sel == SEL_FIXCNT);
    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.freeze = cfg_wdata[CTL_FREEZE_BIT];
            r_d.wake   = cfg_wdata[CTL_WAKE_BIT];
            r_d.en     = cfg_wdata[CTL_EN_BIT];
            r_d.sel    = cfg_wdata[N_CORE-1:0];
        end
        if (wr_fctl) begin
            r_d.fix_run    = cfg_wdata[FIX_RUN_BIT];
            r_d.fix_ovf_en = cfg_wdata[FIX_OVFEN_BIT];
        end
        // freeze on interrupt overrides any same-cycle enable write
        if (irq_fire && r_q.freeze) r_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctrl_o                 = '0;
        ctrl_o[CTL_FREEZE_BIT] = r_q.freeze;
        ctrl_o[CTL_WAKE_BIT]   = r_q.wake;
        ctrl_o[CTL_EN_BIT]     = r_q.en;
        ctrl_o[N_CORE-1:0]     = r_q.sel;
        fix_ctl_o                = '0;
        fix_ctl_o[FIX_RUN_BIT]   = r_q.fix_run;
        fix_ctl_o[FIX_OVFEN_BIT] = r_q.fix_ovf_en;
    end

    assign glb_en_o = r_q.en;

    pmu_cyc_counter #(.CNT_W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (r_q.fix_run & r_q.en),
        .ld_i     (wr_fcnt),
        .ld_val_i (cfg_wdata[CNT_W-1:0]),
        .cnt_o    (fix_cnt_o),
        .wrap_o   (fix_wrap)
    );

    pmu_ovf_status #(.N_SLICE_OVF(N_SLICE_OVF), .N_ARB_OVF(N_ARB_OVF)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .fix_wrap_i   (fix_wrap),
        .fix_ovf_en_i (r_q.fix_ovf_en),
        .arb_ovf_i    (arb_ovf_i),
        .slice_ovf_i  (slice_ovf_i),
        .clr_we_i     (wr_stat),
        .clr_bits_i   (cfg_wdata[ST_W-1:0]),
        .status_o     (status_o),
        .fire_o       (irq_fire)
    );

    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        pmu_pmi_seq u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (irq_fire & r_q.sel[c]),
            .wake_mode_i (r_q.wake),
            .awake_i     (core_awake_i[c]),
            .wake_req_o  (wake_req_o[c]),
            .pmi_o       (pmi_o[c])
        );
    end
endmodule

// File: rtl/pmu_global_ctl_chk.sv
module pmu_global_ctl_chk
    import pmu_glb_pkg::*;
#(
    parameter int N_CORE      = 4,
    parameter int N_SLICE_OVF = 8,
    parameter int N_ARB_OVF   = 2,
    parameter int CNT_W       = 48
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [1:0]             cfg_sel,
    input logic [N_SLICE_OVF-1:0] slice_ovf_i,
    input logic [N_ARB_OVF-1:0]   arb_ovf_i,
    input logic [N_CORE-1:0]      core_awake_i,
    input logic                   glb_en_o,
    input logic [RDBK_W-1:0]      ctrl_o,
    input logic [ST_W-1:0]        status_o,
    input logic [CNT_W-1:0]       fix_cnt_o,
    input logic [N_CORE-1:0]      pmi_o
);
    // R3
    slice_status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ST_SLICE]) |-> $past(|slice_ovf_i));

    // R3
    arb_status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ST_ARB]) |-> $past(|arb_ovf_i));

    // R4
    status_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_o) & ~status_o) != '0) |-> $past(cfg_we && cfg_sel == SEL_STATUS));

    // R2
    freeze_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(glb_en_o) && !$past(cfg_we && cfg_sel == SEL_CTRL)) |-> $past(ctrl_o[CTL_FREEZE_BIT]));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fix_cnt_o != $past(fix_cnt_o)) && !$past(cfg_we && cfg_sel == SEL_FIXCNT))
            |-> (fix_cnt_o == $past(fix_cnt_o) + 1'b1));

    // R7
    pmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi_o != '0) |=> ((pmi_o & $past(pmi_o)) == '0));

    for (genvar c = 0; c < N_CORE; c++) begin : g_core_chk
        // R8 R9
        pmi_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pmi_o[c] |-> $past(core_awake_i[c]));
    end
endmodule

bind pmu_global_ctl pmu_global_ctl_chk #(
    .N_CORE(N_CORE), .N_SLICE_OVF(N_SLICE_OVF), .N_ARB_OVF(N_ARB_OVF), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .slice_ovf_i  (slice_ovf_i),
    .arb_ovf_i    (arb_ovf_i),
    .core_awake_i (core_awake_i),
    .glb_en_o     (glb_en_o),
    .ctrl_o       (ctrl_o),
    .status_o     (status_o),
    .fix_cnt_o    (fix_cnt_o),
    .pmi_o        (pmi_o)
);

// File: tb/sim_pmu_global_ctl.sv
module sim_pmu_global_ctl;
    localparam int NC = 4;
    localparam int NS = 8;
    localparam int NA = 2;
    localparam int CW = 48;

    localparam int K_CTRL = 0, K_STAT = 1, K_CNT = 2, K_PMI = 3, K_WAKE = 4, K_GLB = 5, K_FCTL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [63:0]   cfg_wdata = '0;
    logic [NS-1:0] slice_ovf_i = '0;
    logic [NA-1:0] arb_ovf_i = '0;
    logic [NC-1:0] core_awake_i = '0;
    logic          glb_en_o;
    logic [31:0]   ctrl_o;
    logic [3:0]    status_o;
    logic [31:0]   fix_ctl_o;
    logic [CW-1:0] fix_cnt_o;
    logic [NC-1:0] wake_req_o;
    logic [NC-1:0] pmi_o;

    pmu_global_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .slice_ovf_i(slice_ovf_i), .arb_ovf_i(arb_ovf_i), .core_awake_i(core_awake_i),
        .glb_en_o(glb_en_o), .ctrl_o(ctrl_o), .status_o(status_o), .fix_ctl_o(fix_ctl_o),
        .fix_cnt_o(fix_cnt_o), .wake_req_o(wake_req_o), .pmi_o(pmi_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    event  sb_ev;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic logic [63:0] pick(int kind);
        case (kind)
            K_CTRL:  return {32'd0, ctrl_o};
            K_STAT:  return {60'd0, status_o};
            K_CNT:   return {16'd0, fix_cnt_o};
            K_PMI:   return {60'd0, pmi_o};
            K_WAKE:  return {60'd0, wake_req_o};
            K_GLB:   return {63'd0, glb_en_o};
            default: return {32'd0, fix_ctl_o};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sb_ev);
            while (sb.size() != 0) begin
                item_t it;
                logic [63:0] act;
                it  = sb.pop_front();
                act = pick(it.kind);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(int kind, logic [63:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
        -> sb_ev;
        #1;
    endtask

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] sel, logic [63:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        step();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] x;
        step(3);
        rst_n = 1'b1;
        // R10 reset state
        expect_val(K_CTRL, 0, "R10");
        expect_val(K_STAT, 0, "R10");
        expect_val(K_CNT,  0, "R10");
        expect_val(K_FCTL, 0, "R10");
        expect_val(K_PMI,  0, "R10");
        expect_val(K_WAKE, 0, "R10");

        // R11 counter control masking, R5 no count while global enable off
        wr(2'd2, '1);
        expect_val(K_FCTL, 64'h0050_0000, "R11");
        wr(2'd2, 0);
        expect_val(K_CNT, 0, "R5 global off");

        // R1 control masking
        wr(2'd0, '1);
        expect_val(K_CTRL, 64'hE000_000F, "R1");
        expect_val(K_GLB, 1, "R1");
        wr(2'd0, 0);

        // R5 counting and gating
        wr(2'd0, 64'h2000_0000);
        wr(2'd3, 64'd100);
        wr(2'd2, 64'h0040_0000);
        step(5);
        expect_val(K_CNT, 105, "R5 count");
        wr(2'd0, 0);
        step(3);
        expect_val(K_CNT, 106, "R5 gated");
        wr(2'd2, 0);

        // R6 wrap without overflow enable
        core_awake_i = 4'hF;
        wr(2'd0, 64'h2000_0001);
        wr(2'd3, 64'h0000_FFFF_FFFF_FFFE);
        wr(2'd2, 64'h0040_0000);
        step();
        expect_val(K_CNT, 64'h0000_FFFF_FFFF_FFFF, "R5 max");
        step();
        expect_val(K_CNT, 0, "R5 wrap");
        expect_val(K_STAT, 4'b0001, "R6 status");
        expect_val(K_PMI, 0, "R6 no irq");
        wr(2'd2, 0);

        // R4 write-one-to-clear
        wr(2'd1, 0);
        expect_val(K_STAT, 4'b0001, "R4 zero ignored");
        wr(2'd1, 64'hF);
        expect_val(K_STAT, 0, "R4 clear");

        // R6 wrap with overflow enable, R7 pulse
        wr(2'd3, 64'h0000_FFFF_FFFF_FFFF);
        wr(2'd2, 64'h0050_0000);
        step();
        expect_val(K_PMI, 4'b0001, "R6 irq");
        expect_val(K_STAT, 4'b0001, "R6 status");
        step();
        expect_val(K_PMI, 0, "R7 one cycle");
        wr(2'd2, 0);
        wr(2'd1, 64'hF);

        // R3 R8 arbiter source, non-wake routing, core 3 asleep
        core_awake_i = 4'b0011;
        wr(2'd0, 64'h2000_000B);
        arb_ovf_i = 2'b01;
        step();
        arb_ovf_i = '0;
        expect_val(K_STAT, 4'b0010, "R3 arb");
        expect_val(K_PMI, 4'b0011, "R8 awake only");
        expect_val(K_WAKE, 0, "R8 no wake");
        step();
        expect_val(K_STAT, 4'b0010, "R3 sticky");
        slice_ovf_i = 8'h80;
        step();
        slice_ovf_i = '0;
        expect_val(K_STAT, 4'b1010, "R3 slice");
        expect_val(K_PMI, 4'b0011, "R8");
        step();
        wr(2'd1, 64'h2);
        expect_val(K_STAT, 4'b1000, "R4 selective");
        wr(2'd1, 64'hF);

        // R7 held source gives one interrupt
        slice_ovf_i = 8'h01;
        step();
        expect_val(K_PMI, 4'b0011, "R7 first");
        step();
        expect_val(K_PMI, 0, "R7 held");
        step();
        expect_val(K_PMI, 0, "R7 held");
        slice_ovf_i = '0;
        step(2);
        wr(2'd1, 64'hF);

        // R4 hardware set beats clear
        slice_ovf_i = 8'h01;
        wr(2'd1, 64'hF);
        slice_ovf_i = '0;
        expect_val(K_STAT, 4'b1000, "R4 set wins");
        step();
        wr(2'd1, 64'hF);

        // R9 wake mode
        core_awake_i = 4'b0001;
        wr(2'd0, 64'h6000_0005);
        arb_ovf_i = 2'b10;
        step();
        arb_ovf_i = '0;
        expect_val(K_WAKE, 4'b0101, "R9 wake first");
        expect_val(K_PMI, 0, "R9 no pmi yet");
        step();
        expect_val(K_PMI, 4'b0001, "R9 core0");
        expect_val(K_WAKE, 4'b0100, "R9 core2 waits");
        step();
        expect_val(K_PMI, 0, "R9");
        expect_val(K_WAKE, 4'b0100, "R9 hold");
        core_awake_i = 4'b0101;
        step();
        expect_val(K_PMI, 4'b0100, "R9 core2");
        expect_val(K_WAKE, 0, "R9 released");
        step();
        expect_val(K_PMI, 0, "R9");
        wr(2'd1, 64'hF);

        // R2 freeze on interrupt
        core_awake_i = 4'hF;
        wr(2'd0, 64'hA000_0001);
        wr(2'd2, 64'h0040_0000);
        arb_ovf_i = 2'b01;
        step();
        arb_ovf_i = '0;
        expect_val(K_GLB, 0, "R2 frozen");
        expect_val(K_CTRL, 64'h8000_0001, "R2 ctrl");
        expect_val(K_PMI, 4'b0001, "R2 irq");
        x = fix_cnt_o;
        step(3);
        expect_val(K_CNT, {16'd0, x}, "R2 counter stopped");
        wr(2'd0, 64'hA000_0001);
        expect_val(K_GLB, 1, "R2 rearm");
        step(2);
        expect_val(K_CNT, {16'd0, x + 48'd2}, "R2 counting again");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule